// File: doc/BRIEF.md
# DMA Channel Start-Delay Controller

This block sits beside a processor and decides, clock by clock, which of four transfer channels may move the next unit on the shared bus. Software arms a channel by raising its enable bit. A freshly armed channel must let a short start-up wait elapse before it can compete. Once the wait has run out, the lowest-numbered ready channel receives a grant. The grant is held until the bus side reports that the unit has moved.

When a unit completes, the block can raise sticky interrupt bits in a flag vector. There is one bit per channel, placed at a base offset. The last channel can also raise a separate cartridge-request bit. The processor's halted state blocks new grants, but the start-up wait keeps counting down while the processor is halted. Grants are not tied to instruction boundaries. A grant is issued in the first clock after a channel becomes ready. Address generation and the data path belong to other blocks.

Top module: `dma_start_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `grant_valid` is 0 and `irq_flags` is all zero.
- R2: Arming is counted in rising clock edges. The first edge that samples `chan_en[i]` high after it was low arms channel i. The next two edges count down the start-up wait. If no other channel is granted, `grant_valid` rises with `grant_id` = i on the fourth edge, and not earlier.
- R3: The wait counter only decrements while the channel stays enabled. If `chan_en[i]` is sampled low, the channel is disarmed and its counter is cleared. Re-enabling it restarts the full wait, so the grant again comes on the fourth edge after re-enabling.
- R4: While `cpu_stopped` is high, no new grant is issued. The start-up wait still elapses during that time, so a channel whose wait is over is granted on the first edge at which `cpu_stopped` is sampled low.
- R5: When several channels are ready on the same edge, the lowest channel index is granted.
- R6: At most one grant is active at a time. `grant_valid` and `grant_id` hold until an edge samples `xfer_done` high while `grant_valid` is high. That edge drops `grant_valid`, and the next grant can come no earlier than the following edge. `xfer_done` has no effect while no grant is active.
- R7: On the edge that completes a unit for channel i with `chan_irq_en[i]` high, bit 8+i of `irq_flags` is set. No flag bit rises at any other time.
- R8: On the edge that completes a unit for channel 3 with `chan_drq_en[3]` high, bit 13 of `irq_flags` (the cartridge request) is set. This is independent of `chan_irq_en[3]`. `chan_drq_en` of channels 0 to 2 sets nothing.
- R9: Flag bits are sticky. A bit is cleared only by an edge that samples a 1 at the same position of `irq_clr`. A completion that sets a bit on the same edge takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 4 | Per-channel enable; a low-to-high change arms the channel |
| chan_irq_en | input | 4 | Per-channel completion interrupt enable |
| chan_drq_en | input | 4 | Per-channel cartridge request enable (only channel 3 acts on it) |
| cpu_stopped | input | 1 | Processor halted; blocks new grants |
| xfer_done | input | 1 | Bus side reports that the granted unit has moved |
| irq_clr | input | 14 | Write-one-to-clear mask for `irq_flags` |
| grant_valid | output | 1 | A channel currently owns the bus for one unit |
| grant_id | output | 2 | Index of the granted channel |
| irq_flags | output | 14 | Sticky flags: bits 8..11 are channel completions, bit 13 is the cartridge request |

## Verification
Directed patterns each isolate one timing or ordering rule:
- A single channel enabled alone pins the exact edge of the first grant.
- A channel dropped in mid-wait and re-enabled shows whether the counter is cleared or resumed.
- A halted processor during arming shows that the wait elapses but the grant is withheld.
- Two channels armed together, with the lower one then withdrawn, expose the priority order.
- The channel-3 case with only request enable set separates the cartridge bit from the channel bit.
- A clear that lands on the same edge as a completion shows which one wins.

A long seeded random run then toggles enables, halt, done, interrupt enables and clears sparsely. It compares every cycle against a bench-side cycle model, which catches interactions between re-arming, halting and back-to-back grants that the directed cases do not reach.

// File: rtl/dma_start_pkg.sv
// Shared types for the DMA start-delay controller.
// Assumes: only the arbiter state encoding needs sharing.
package dma_start_pkg;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_t;

endpackage

// File: rtl/dma_start_chan.sv
// One channel's arming logic.
// - Tracks whether the channel is armed.
// - Counts down the start-up wait while the channel stays enabled.
// - Reports readiness to the arbiter.
// Assumes: en is a level from a software register, sampled each clock.
module dma_start_chan #(
    parameter int WAIT_INIT = 2,
    parameter int WAIT_W    = $clog2(WAIT_INIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cpu_stopped,
    output logic ready
);

    logic              armed_q;
    logic [WAIT_W-1:0] wait_q;

    // Arm on enable, count the wait down, disarm and clear when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            wait_q  <= '0;
        end else if (!en) begin
            armed_q <= 1'b0;
            wait_q  <= '0;
        end else if (!armed_q) begin
            armed_q <= 1'b1;
            wait_q  <= WAIT_W'(WAIT_INIT);
        end else if (wait_q != '0) begin
            wait_q  <= wait_q - 1'b1;
        end
    end

    // Ready when armed, still enabled, wait over and processor running.
    assign ready = armed_q & en & (wait_q == '0) & ~cpu_stopped;

endmodule

// File: rtl/dma_start_arb.sv
// Fixed-priority arbiter with a one-unit grant.
// - Picks the lowest-index ready channel.
// - Holds the grant until the bus side signals completion.
// - Outputs a completion strobe with the finished channel index.
// Assumes: xfer_done is only meaningful while a grant is active.
module dma_start_arb
    import dma_start_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ID_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ready,
    input  logic              xfer_done,
    output logic              grant_valid,
    output logic [ID_W-1:0]   grant_id,
    output logic              done_stb
);

    arb_state_t      state_q;
    logic [ID_W-1:0] id_q;
    logic [ID_W-1:0] pick;

    // Lowest ready index wins: scan downward so the last hit is the lowest.
    always_comb begin
        pick = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (ready[i]) pick = ID_W'(i);
        end
    end

    // Grant state: idle until something is ready, busy until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            id_q    <= '0;
        end else begin
            case (state_q)
                ARB_IDLE: if (|ready) begin
                    state_q <= ARB_BUSY;
                    id_q    <= pick;
                end
                ARB_BUSY: if (xfer_done) state_q <= ARB_IDLE;
                default:  state_q <= ARB_IDLE;
            endcase
        end
    end

    assign grant_valid = (state_q == ARB_BUSY);
    assign grant_id    = id_q;
    // Completion strobe for the flag logic.
    assign done_stb    = grant_valid & xfer_done;

endmodule

// File: rtl/dma_start_irq.sv
// Sticky completion flags.
// - Sets one bit per channel at DMA_BASE + index on completion.
// - The cartridge channel may also set CART_BIT.
// - Write-one-to-clear; a set on the same edge wins.
// Assumes: done_stb is a one-cycle strobe qualified by the arbiter.
module dma_start_irq #(
    parameter int NUM_CH   = 4,
    parameter int ID_W     = $clog2(NUM_CH),
    parameter int FLAG_W   = 14,
    parameter int DMA_BASE = 8,
    parameter int CART_BIT = 13,
    parameter int CART_CH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_stb,
    input  logic [ID_W-1:0]   done_id,
    input  logic [NUM_CH-1:0] irq_en,
    input  logic [NUM_CH-1:0] drq_en,
    input  logic [FLAG_W-1:0] clr,
    output logic [FLAG_W-1:0] flags
);

    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] flags_q;

    // Build the set mask from the finished channel and its enables.
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (done_stb && done_id == ID_W'(i)) begin
                if (irq_en[i]) set_vec[DMA_BASE + i] = 1'b1;
                if (i == CART_CH && drq_en[i]) set_vec[CART_BIT] = 1'b1;
            end
        end
    end

    // Sticky update: clear requested bits, then apply new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr) | set_vec;
    end

    assign flags = flags_q;

endmodule

// File: rtl/dma_start_ctrl.sv
// Top of the DMA start-delay controller.
// - One arming unit per channel feeds a fixed-priority one-unit arbiter.
// - The arbiter's completion strobe drives the sticky flag register.
// Assumes: the address and data path are handled elsewhere.
module dma_start_ctrl #(
    parameter int NUM_CH     = 4,
    parameter int START_WAIT = 2,
    parameter int FLAG_W     = 14,
    parameter int DMA_BASE   = 8,
    parameter int CART_BIT   = 13,
    parameter int CART_CH    = NUM_CH - 1,
    localparam int ID_W      = $clog2(NUM_CH),
    localparam int WAIT_W    = $clog2(START_WAIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] chan_irq_en,
    input  logic [NUM_CH-1:0] chan_drq_en,
    input  logic              cpu_stopped,
    input  logic              xfer_done,
    input  logic [FLAG_W-1:0] irq_clr,
    output logic              grant_valid,
    output logic [ID_W-1:0]   grant_id,
    output logic [FLAG_W-1:0] irq_flags
);

    logic [NUM_CH-1:0] ready;
    logic              done_stb;

    // One arming unit per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dma_start_chan #(
            .WAIT_INIT (START_WAIT),
            .WAIT_W    (WAIT_W)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .en          (chan_en[g]),
            .cpu_stopped (cpu_stopped),
            .ready       (ready[g])
        );
    end

    dma_start_arb #(
        .NUM_CH (NUM_CH),
        .ID_W   (ID_W)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready       (ready),
        .xfer_done   (xfer_done),
        .grant_valid (grant_valid),
        .grant_id    (grant_id),
        .done_stb    (done_stb)
    );

    dma_start_irq #(
        .NUM_CH   (NUM_CH),
        .ID_W     (ID_W),
        .FLAG_W   (FLAG_W),
        .DMA_BASE (DMA_BASE),
        .CART_BIT (CART_BIT),
        .CART_CH  (CART_CH)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_stb (done_stb),
        .done_id  (grant_id),
        .irq_en   (chan_irq_en),
        .drq_en   (chan_drq_en),
        .clr      (irq_clr),
        .flags    (irq_flags)
    );

endmodule

// File: rtl/dma_start_chk.sv
// Protocol checker for dma_start_ctrl, attached by bind.
// Watches only top-level ports and keeps its own enable history.
module dma_start_chk #(
    parameter int NUM_CH = 4,
    parameter int FLAG_W = 14,
    localparam int ID_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] chan_en,
    input logic              cpu_stopped,
    input logic              xfer_done,
    input logic [FLAG_W-1:0] irq_clr,
    input logic              grant_valid,
    input logic [ID_W-1:0]   grant_id,
    input logic [FLAG_W-1:0] irq_flags
);

    logic [NUM_CH-1:0] en_d1, en_d2, en_d3;

    // Enable history over the last three edges, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d1 <= '0;
            en_d2 <= '0;
            en_d3 <= '0;
        end else begin
            en_d1 <= chan_en;
            en_d2 <= en_d1;
            en_d3 <= en_d2;
        end
    end

    // R2 / R3: a new grant needs three consecutive sampled-high enables.
    a_r2_wait_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> (en_d1[grant_id] & en_d2[grant_id] & en_d3[grant_id]));

    // R4: no new grant while the processor is halted.
    a_r4_stopped_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && cpu_stopped) |=> !grant_valid);

    // R6: grant is held, with a stable index, until done.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !xfer_done) |=> (grant_valid && $stable(grant_id)));

    // R6: done releases the grant on the next cycle.
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && xfer_done) |=> !grant_valid);

    // R7 / R8: flags rise only on a completion edge.
    a_r7_set_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_flags & ~$past(irq_flags)) != '0) |-> $past(grant_valid && xfer_done));

    // R9: a flag only falls where a clear was requested.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(irq_flags) & ~$past(irq_clr) & ~irq_flags) == '0));

endmodule

bind dma_start_ctrl dma_start_chk #(
    .NUM_CH (NUM_CH),
    .FLAG_W (FLAG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_en     (chan_en),
    .cpu_stopped (cpu_stopped),
    .xfer_done   (xfer_done),
    .irq_clr     (irq_clr),
    .grant_valid (grant_valid),
    .grant_id    (grant_id),
    .irq_flags   (irq_flags)
);

// File: tb/dma_start_ctrl_tb.sv
// Self-checking bench: directed corner cases, then a seeded random run
// compared cycle by cycle against a bench-side model.
module dma_start_ctrl_tb;

    localparam int NCH  = 4;
    localparam int FW   = 14;
    localparam int BASE = 8;
    localparam int CART = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NCH-1:0] en = '0, irq_en = '0, drq_en = '0;
    logic          stopped = 1'b0, done = 1'b0;
    logic [FW-1:0] clr = '0;
    logic          gv;
    logic [1:0]    gid;
    logic [FW-1:0] flags;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_start_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .chan_en (en), .chan_irq_en (irq_en),
        .chan_drq_en (drq_en), .cpu_stopped (stopped), .xfer_done (done),
        .irq_clr (clr), .grant_valid (gv), .grant_id (gid), .irq_flags (flags)
    );

    // ---------------- bench-side cycle model ----------------
    logic          m_act [NCH];
    int            m_wait [NCH];
    logic          m_gv;
    int            m_gid;
    logic [FW-1:0] m_flags;

    function automatic int lowest_ready(input logic [NCH-1:0] r);
        for (int i = 0; i < NCH; i++) if (r[i]) return i;
        return -1;
    endfunction

    function automatic logic [FW-1:0] done_flags(input int id,
            input logic [NCH-1:0] ie, input logic [NCH-1:0] de);
        logic [FW-1:0] s = '0;
        if (ie[id]) s[BASE + id] = 1'b1;
        if (id == 3 && de[3]) s[CART] = 1'b1;
        return s;
    endfunction

    always @(posedge clk) begin
        logic [NCH-1:0] rdy;
        logic [FW-1:0]  s;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin m_act[i] = 0; m_wait[i] = 0; end
            m_gv = 0; m_gid = 0; m_flags = '0;
        end else begin
            for (int i = 0; i < NCH; i++)
                rdy[i] = m_act[i] && en[i] && m_wait[i] == 0 && !stopped;
            s = '0;
            if (!m_gv) begin
                if (rdy != '0) begin m_gv = 1; m_gid = lowest_ready(rdy); end
            end else if (done) begin
                s = done_flags(m_gid, irq_en, drq_en);
                m_gv = 0;
            end
            m_flags = (m_flags & ~clr) | s;
            for (int i = 0; i < NCH; i++) begin
                if (!en[i]) begin m_act[i] = 0; m_wait[i] = 0; end
                else if (!m_act[i]) begin m_act[i] = 1; m_wait[i] = 2; end
                else if (m_wait[i] != 0) m_wait[i] = m_wait[i] - 1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_grant(input string req, input logic v, input int id);
        check(gv === v && (!v || gid === 2'(id)), req, {gv, 2'b0, gid}, {v, 2'b0, 2'(id)});
    endtask

    task automatic finish_unit();
        done = 1'b1; tick(1); done = 1'b0;
    endtask

    task automatic quiesce();
        en = '0; irq_en = '0; drq_en = '0; stopped = 1'b0;
        tick(1);
        if (gv) finish_unit();
        clr = '1; tick(1); clr = '0;
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        tick(3);
        // R1: reset state while reset is held
        chk_grant("R1 in reset", 1'b0, 0);
        check(flags === '0, "R1 flags in reset", 32'(flags), 0);
        rst_n = 1'b1;
        tick(1);
        chk_grant("R1 after reset", 1'b0, 0);
        check(flags === '0, "R1 flags after reset", 32'(flags), 0);

        // R2: lone channel 1, grant appears exactly on the fourth edge
        irq_en = 4'b0010;
        en[1] = 1'b1;
        tick(3);
        chk_grant("R2 no early grant", 1'b0, 0);
        tick(1);
        chk_grant("R2 grant on fourth edge", 1'b1, 1);

        // R6: grant holds without done
        tick(3);
        chk_grant("R6 grant held", 1'b1, 1);
        finish_unit();
        chk_grant("R6 released after done", 1'b0, 0);
        // R7: channel 1 completion sets bit 9
        check(flags === FW'(1 << (BASE + 1)), "R7 ch1 flag", 32'(flags), 1 << (BASE + 1));
        tick(1);
        chk_grant("R6 regrant after release", 1'b1, 1);
        quiesce();

        // R6: done without a grant does nothing
        done = 1'b1; tick(2); done = 1'b0;
        chk_grant("R6 stray done", 1'b0, 0);
        check(flags === '0, "R6 stray done flags", 32'(flags), 0);

        // R3: drop during wait, re-enable restarts full delay
        en[0] = 1'b1; tick(2);
        en[0] = 1'b0; tick(1);
        en[0] = 1'b1; tick(3);
        chk_grant("R3 restart no early grant", 1'b0, 0);
        tick(1);
        chk_grant("R3 restart grant", 1'b1, 0);
        quiesce();

        // R4: halted processor blocks grant, wait still elapses
        stopped = 1'b1; en[2] = 1'b1; tick(6);
        chk_grant("R4 blocked while stopped", 1'b0, 0);
        stopped = 1'b0; tick(1);
        chk_grant("R4 grant on first running edge", 1'b1, 2);
        quiesce();

        // R5: lowest index wins
        en = 4'b0110; tick(4);
        chk_grant("R5 lowest of two", 1'b1, 1);
        finish_unit();
        en[1] = 1'b0; tick(1);
        chk_grant("R5 next channel after withdrawal", 1'b1, 2);
        quiesce();

        // R8: channel 3 with request enable only -> cartridge bit alone
        drq_en = 4'b1100; irq_en = 4'b0000; en[3] = 1'b1; tick(4);
        chk_grant("R8 ch3 grant", 1'b1, 3);
        finish_unit();
        check(flags === FW'(1 << CART), "R8 cart bit only", 32'(flags), 1 << CART);
        quiesce();

        // R8: channel 2 with request enable sets only its own bit
        drq_en = 4'b0100; irq_en = 4'b0100; en[2] = 1'b1; tick(4);
        finish_unit();
        check(flags === FW'(1 << (BASE + 2)), "R8 no cart from ch2", 32'(flags), 1 << (BASE + 2));

        // R9: clearing another bit leaves bit 10 sticky
        en = '0;
        clr = FW'(1 << (BASE + 1)); tick(1); clr = '0; tick(2);
        check(flags === FW'(1 << (BASE + 2)), "R9 sticky", 32'(flags), 1 << (BASE + 2));
        clr = FW'(1 << (BASE + 2)); tick(1); clr = '0;
        check(flags === '0, "R9 cleared", 32'(flags), 0);

        // R9: set wins over clear on the same edge
        en[2] = 1'b1; tick(4);
        done = 1'b1; clr = FW'(1 << (BASE + 2)); tick(1);
        done = 1'b0; clr = '0;
        check(flags === FW'(1 << (BASE + 2)), "R9 set beats clear", 32'(flags), 1 << (BASE + 2));
        quiesce();

        // R2..R9: random run against the model
        for (int c = 0; c < 4000; c++) begin
            check(gv === m_gv && (!m_gv || gid === 2'(m_gid)), "R9 model grant",
                  {gv, 2'b0, gid}, {m_gv, 2'b0, 2'(m_gid)});
            check(flags === m_flags, "R7 model flags", 32'(flags), 32'(m_flags));
            for (int i = 0; i < NCH; i++)
                if ($urandom_range(7) == 0) en[i] = ~en[i];
            stopped = ($urandom_range(5) == 0);
            done    = ($urandom_range(2) == 0);
            irq_en  = 4'($urandom);
            drq_en  = 4'($urandom);
            clr     = FW'($urandom & $urandom & $urandom);
            tick(1);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule